// File: doc/BRIEF.md
# ADC External-Trigger Conversion Sequencer

This block controls an analog-to-digital converter whose conversions are started by an edge on an external trigger pin. Software programs a control word (enable, scan/select, conversion length), an edge qualifier and a target channel through a small write port. The trigger pin is synchronized inside the block, and a qualified edge launches a conversion on one of four channels. The converter core itself is outside the block. The block issues a start pulse and the channel number, counts a fixed number of conversion clocks, and then samples the core's result word into that channel's result register.

In select mode a trigger converts the chosen channel once. In scan mode a trigger converts channels 0 up to the chosen channel in ascending order. In both modes the block then waits for the next qualified edge, and this repeats for as long as enable stays set. A qualified edge that arrives during a conversion throws the conversion away and starts again from the beginning. A configuration write, or clearing enable, abandons the conversion silently. Four fixed conversion lengths are derived from the parameter `CONV_BASE`: base, 1.5×base, 2×base and 3×base clocks.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset: busy, eoc_irq and conv_start are 0, all four result registers are 0, enable is off, the edge qualifier is rising-only, the channel is 0, select mode is active and the length code is 0.
- R2: Edge qualifier (address 1, wdata[1:0]): 00 means no edge is valid, 01 rising only, 10 falling only, 11 both edges.
- R3: With enable set, nothing starts until a qualified edge arrives. conv_start pulses for one cycle only when a conversion or a scan step begins.
- R4: When a conversion completes, conv_data is stored into the result register of the channel being converted. In the same cycle eoc_irq pulses for one cycle, but only at the end of the last channel.
- R5: busy is 1 from the cycle of a start until completion or abort, and 0 while the block waits for a trigger.
- R6: A qualified edge during a conversion restarts it from the beginning at full length. This includes an edge in the completion cycle, which wins: no result is stored and no interrupt is raised.
- R7: In select mode (control bit 1 = 0), conv_chan equals the channel field (address 2, wdata[1:0]) throughout the conversion.
- R8: In scan mode (control bit 1 = 1), one trigger converts channels 0, 1, … up to the channel field in ascending order, with one conv_start for each channel.
- R9: A write to address 0, 1 or 2 stores the field and sets busy to 0 at the next edge, with no result and no interrupt; this beats a trigger in the same cycle. A write to address 3 changes nothing.
- R10: When enable (control bit 0) is 0, any conversion is abandoned with busy 0, no interrupt and no stored result.
- R11: Length code (control bits 3:2) 0..3 selects CONV_BASE, CONV_BASE·3/2, 2·CONV_BASE or 3·CONV_BASE clocks from the start edge to the completion edge.
- R12: trig_in passes through a two-flop synchronizer. A level change driven before clock edge k produces conv_start and busy after clock edge k+2.
- R13: The unit keeps converting on every later qualified edge for as long as enable stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_addr | input | 2 | 0 control, 1 edge qualifier, 2 channel, 3 unused |
| reg_wdata | input | 4 | Write data |
| trig_in | input | 1 | Asynchronous external trigger |
| conv_data | input | DW | Result word from the converter core |
| conv_start | output | 1 | One-cycle start pulse to the core |
| conv_chan | output | 2 | Channel being converted |
| busy | output | 1 | Conversion in progress |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |
| res0 | output | DW | Result register, channel 0 |
| res1 | output | DW | Result register, channel 1 |
| res2 | output | DW | Result register, channel 2 |
| res3 | output | DW | Result register, channel 3 |

## Verification
Two pairs of events can land in the same cycle: a qualified edge with the completion of a conversion, and a configuration write with a qualified edge. The bench provokes the first pair by sweeping the spacing between two trigger edges across the conversion length. It provokes the second by sweeping a write's offset across the synchronizer delay after a trigger edge. A behavioural model applies the stated priority (write, then disable, then trigger, then completion), and every cycle is judged by comparing busy, conv_start, eoc_irq, the channel and all result registers against that model.

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
  parameter int DW        = 10,
  parameter int CONV_BASE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [3:0]    reg_wdata,
  input  logic          trig_in,
  input  logic [DW-1:0] conv_data,
  output logic          conv_start,
  output logic [1:0]    conv_chan,
  output logic          busy,
  output logic          eoc_irq,
  output logic [DW-1:0] res0,
  output logic [DW-1:0] res1,
  output logic [DW-1:0] res2,
  output logic [DW-1:0] res3
);
  localparam int CW = $clog2(3*CONV_BASE+1);

  logic          en_q, scan_q;
  logic [1:0]    freq_q, edge_q, chsel_q, ch_q;
  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q, len;
  logic [DW-1:0] res_q [4];

  wire rise     = sync_q[1] & ~sync_q[2];
  wire fall     = ~sync_q[1] & sync_q[2];
  wire trig_ok  = (rise & edge_q[0]) | (fall & edge_q[1]);
  wire cfg_hit  = reg_we && (reg_addr != 2'd3);
  wire last_ch  = !scan_q || (ch_q == chsel_q);

  always_comb begin
    case (freq_q)
      2'd0:    len = CW'(CONV_BASE - 1);
      2'd1:    len = CW'(CONV_BASE + CONV_BASE/2 - 1);
      2'd2:    len = CW'(2*CONV_BASE - 1);
      default: len = CW'(3*CONV_BASE - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], trig_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; scan_q <= 1'b0; freq_q <= 2'd0;
      edge_q <= 2'b01; chsel_q <= 2'd0;
    end else if (cfg_hit) begin
      case (reg_addr)
        2'd0:    {freq_q, scan_q, en_q} <= reg_wdata;
        2'd1:    edge_q  <= reg_wdata[1:0];
        default: chsel_q <= reg_wdata[1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt_q <= '0; ch_q <= 2'd0;
      conv_start <= 1'b0; eoc_irq <= 1'b0;
      for (int i = 0; i < 4; i++) res_q[i] <= '0;
    end else begin
      conv_start <= 1'b0;
      eoc_irq    <= 1'b0;
      if (cfg_hit || !en_q) begin
        busy <= 1'b0;
      end else if (trig_ok) begin
        busy       <= 1'b1;
        cnt_q      <= len;
        ch_q       <= scan_q ? 2'd0 : chsel_q;
        conv_start <= 1'b1;
      end else if (busy) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          res_q[ch_q] <= conv_data;
          if (last_ch) begin
            busy    <= 1'b0;
            eoc_irq <= 1'b1;
          end else begin
            ch_q       <= ch_q + 2'd1;
            cnt_q      <= len;
            conv_start <= 1'b1;
          end
        end
      end
    end
  end

  assign conv_chan = ch_q;
  assign res0 = res_q[0];
  assign res1 = res_q[1];
  assign res2 = res_q[2];
  assign res3 = res_q[3];
endmodule

module adc_trig_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic       busy,
  input logic       eoc_irq,
  input logic       conv_start,
  input logic [1:0] conv_chan,
  input logic       en,
  input logic       scan,
  input logic [1:0] chsel
);
  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> $past(busy)); // R4
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq); // R4
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> !busy); // R5
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(en) && busy)); // R3
  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != 2'd3) |=> (!busy && !eoc_irq)); // R9
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reg_we) |=> (!busy && !eoc_irq)); // R10
  AST_SELECT_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan) |-> (conv_chan == chsel)); // R7
  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && scan) |-> (conv_chan <= chsel)); // R8
endmodule

bind adc_trig_seq adc_trig_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .busy(busy), .eoc_irq(eoc_irq), .conv_start(conv_start),
  .conv_chan(conv_chan), .en(en_q), .scan(scan_q), .chsel(chsel_q)
);

// File: tb/tb_adc_trig_seq.sv
module tb_adc_trig_seq;
  localparam int DW = 10;
  localparam int CONV_BASE = 8;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, trig_in = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [DW-1:0] conv_data = '0;
  logic conv_start, busy, eoc_irq;
  logic [1:0] conv_chan;
  logic [DW-1:0] res0, res1, res2, res3;

  adc_trig_seq #(.DW(DW), .CONV_BASE(CONV_BASE)) dut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .trig_in, .conv_data,
    .conv_start, .conv_chan, .busy, .eoc_irq, .res0, .res1, .res2, .res3);

  always #2.5 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  bit m_en, m_scan, m_busy, m_start, m_irq;
  bit [1:0] m_freq, m_edge, m_chsel;
  int m_cnt, m_ch;
  int m_res[4];
  bit hist[$];

  function automatic int conv_len(bit [1:0] f);
    case (f)
      2'd0: return CONV_BASE;
      2'd1: return CONV_BASE + CONV_BASE/2;
      2'd2: return 2*CONV_BASE;
      default: return 3*CONV_BASE;
    endcase
  endfunction

  always @(posedge clk) begin
    bit rise, fall, valid;
    if (!rst_n) begin
      m_en = 0; m_scan = 0; m_freq = 0; m_edge = 2'b01; m_chsel = 0;
      m_busy = 0; m_start = 0; m_irq = 0; m_cnt = 0; m_ch = 0;
      foreach (m_res[i]) m_res[i] = 0;
      hist = '{0, 0, 0};
    end else begin
      rise = hist[1] && !hist[2];
      fall = !hist[1] && hist[2];
      valid = (rise && m_edge[0]) || (fall && m_edge[1]);
      hist.push_front(trig_in);
      void'(hist.pop_back());
      m_start = 0; m_irq = 0;
      if (reg_we && reg_addr != 2'd3) begin
        m_busy = 0;
        if (reg_addr == 0) begin
          m_en = reg_wdata[0]; m_scan = reg_wdata[1]; m_freq = reg_wdata[3:2];
        end else if (reg_addr == 1) m_edge = reg_wdata[1:0];
        else m_chsel = reg_wdata[1:0];
      end else if (!m_en) begin
        m_busy = 0;
      end else if (valid) begin
        m_busy = 1; m_cnt = conv_len(m_freq); m_start = 1;
        m_ch = m_scan ? 0 : int'(m_chsel);
      end else if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_res[m_ch] = int'(conv_data);
          if (!m_scan || m_ch == int'(m_chsel)) begin
            m_busy = 0; m_irq = 1;
          end else begin
            m_ch++; m_cnt = conv_len(m_freq); m_start = 1;
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(busy == m_busy, "R5 busy", busy, m_busy);
      chk(eoc_irq == m_irq, "R4 eoc_irq", eoc_irq, m_irq);
      chk(conv_start == m_start, "R3 conv_start", conv_start, m_start);
      if (m_busy) chk(int'(conv_chan) == m_ch, "R7 conv_chan", conv_chan, m_ch);
      chk(int'(res0) == m_res[0], "R4 res0", res0, m_res[0]);
      chk(int'(res1) == m_res[1], "R4 res1", res1, m_res[1]);
      chk(int'(res2) == m_res[2], "R4 res2", res2, m_res[2]);
      chk(int'(res3) == m_res[3], "R4 res3", res3, m_res[3]);
    end
  end

  always @(negedge clk) conv_data <= DW'(conv_data + 10'd37);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      cur_req = "watchdog";
      chk(0, "timeout", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit [1:0] a, bit [3:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic toggle();
    @(negedge clk);
    trig_in = ~trig_in;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    cur_req = "R1";
    chk(busy == 0 && eoc_irq == 0 && conv_start == 0, "reset outputs", busy, 0);
    chk(res0 == 0 && res1 == 0 && res2 == 0 && res3 == 0, "reset results", res0, 0);

    cur_req = "R3";
    wr(2, 4'd2);
    wr(0, 4'b0001);
    idle(20);
    chk(busy == 0, "no start on enable alone", busy, 0);

    cur_req = "R12";
    @(negedge clk); trig_in = 1;
    @(posedge clk); @(posedge clk); #1;
    chk(busy == 0, "still synchronizing", busy, 0);
    @(posedge clk); #1;
    chk(conv_start == 1 && busy == 1, "start after third edge", conv_start, 1);
    cur_req = "R7"; idle(30);
    chk(eoc_irq == 0 && busy == 0, "idle after select conversion", busy, 0);

    cur_req = "R2";
    wr(1, 4'b0010); toggle(); idle(30); toggle(); idle(30);
    wr(1, 4'b0011); toggle(); idle(30); toggle(); idle(30);
    wr(1, 4'b0000); toggle(); idle(30);
    chk(busy == 0, "no edge qualifies", busy, 0);
    toggle(); idle(30);
    wr(1, 4'b0011);

    cur_req = "R6";
    for (int d = 1; d <= 12; d++) begin
      toggle(); idle(d); toggle(); idle(30);
    end

    cur_req = "R11";
    for (int f = 1; f < 4; f++) begin
      wr(0, 4'(f*4 + 1)); toggle(); idle(40);
    end

    cur_req = "R8";
    wr(0, 4'b1111); wr(2, 4'd3);
    toggle(); idle(110);
    wr(2, 4'd0); toggle(); idle(40);
    wr(0, 4'b0011); wr(2, 4'd2); toggle(); idle(40);

    cur_req = "R13";
    for (int k = 0; k < 4; k++) begin
      toggle(); idle(35);
    end

    cur_req = "R9";
    toggle(); idle(6); wr(1, 4'b0011); idle(40);
    chk(busy == 0, "write abort leaves idle", busy, 0);
    toggle(); idle(6); wr(3, 4'hF); idle(40);
    for (int o = 0; o < 5; o++) begin
      toggle(); idle(o); wr(2, 4'd1); idle(30);
    end

    cur_req = "R10";
    wr(0, 4'b0001);
    toggle(); idle(5); wr(0, 4'b0000); idle(30);
    toggle(); idle(30);
    chk(busy == 0, "disabled stays idle", busy, 0);
    wr(0, 4'b0001); toggle(); idle(30);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule